// File: doc/BRIEF.md
# Task Switch Decision and Task Register Unit

This unit decides, for each far control transfer, whether the transfer becomes a task switch, a plain interrupt return, or an invalid-task-segment fault. It classifies a request by its transfer kind (far jump, far call, interrupt or exception, interrupt return) and by the type of descriptor found at the referenced slot. It also uses the nested-task flag of the current task. For a switch it settles which task segment is the target. That is the referenced segment itself, the segment named inside a task gate, or the back-link of the current task on a nested return.

The target selector goes out on a lookup port. The descriptor table answers in the same cycle with the segment's flavour (32-bit or legacy 16-bit), base and limit. The limit is compared against the minimum for that flavour. A valid target loads the task register's selector together with its hidden base and limit. An invalid target raises a fault and leaves the task register as it was. The unit also reports the nested-task value the new task must start with. Saving and restoring the machine state is left to other logic.

Top module: `task_switch_ctl`

## Requirements
- R1: After reset, sw_req, plain_ret, tss_fault and nt_new are 0, and tr_sel, tr_base and tr_limit are all 0.
- R2: A far jump (xfer_kind 0) or far call (xfer_kind 1) whose descriptor is a task segment (desc_kind 1) or a task gate (desc_kind 2), and whose target passes the limit check, raises sw_req.
- R3: A far jump or far call whose descriptor is of any other type (desc_kind 0) raises none of sw_req, plain_ret or tss_fault, and leaves the task register unchanged.
- R4: An interrupt or exception (xfer_kind 2) raises sw_req only when its table slot holds a task gate. With a task segment or another descriptor type in the slot, it raises no output and leaves the task register unchanged.
- R5: An interrupt return (xfer_kind 3) with eflags_nt 0 raises plain_ret only, and leaves the task register unchanged.
- R6: An interrupt return with eflags_nt 1 raises a task switch whose target is link_sel.
- R7: Through a task gate, the target selector is gate_sel. Otherwise, for a jump, call or interrupt, it is ref_sel. The target selector appears on lkp_sel in the same cycle as the request.
- R8: A 32-bit target (lkp_is32 1) is valid only when lkp_limit is strictly greater than 0x64. At a limit of exactly 0x64 it faults. A limit of 0xFFFFFFFF is valid.
- R9: A legacy 16-bit target (lkp_is32 0) is valid only when lkp_limit is strictly greater than 0x2B. At exactly 0x2B it faults.
- R10: A failed limit check raises tss_fault without sw_req, and the task register keeps its previous selector, base and limit.
- R11: On a switch, tr_sel, tr_base and tr_limit take the target's selector, lkp_base and lkp_limit on the same clock edge.
- R12: With sw_req, nt_new is 1 for a switch entered by call or interrupt, and 0 for one entered by jump or interrupt return.
- R13: sw_req, plain_ret and tss_fault are single-cycle pulses, seen in the cycle after the request edge, and at most one of them is high at a time. They stay 0 while req_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A transfer request is present this cycle |
| xfer_kind | input | 2 | 0 far jump, 1 far call, 2 interrupt/exception, 3 interrupt return |
| desc_kind | input | 2 | 0 other, 1 task segment, 2 task gate, 3 reserved (treated as other) |
| eflags_nt | input | 1 | Nested-task flag of the current task |
| ref_sel | input | 16 | Selector named by the transfer |
| gate_sel | input | 16 | Task segment selector held inside a task gate |
| link_sel | input | 16 | Back-link selector of the current task |
| lkp_sel | output | 16 | Target selector sent to the descriptor table |
| lkp_is32 | input | 1 | Target is a 32-bit segment (1) or legacy 16-bit (0) |
| lkp_base | input | 32 | Base of the target segment |
| lkp_limit | input | 32 | Limit of the target segment |
| sw_req | output | 1 | Task switch pulse |
| plain_ret | output | 1 | Plain return pulse |
| tss_fault | output | 1 | Invalid task segment pulse |
| nt_new | output | 1 | Nested-task value for the new task, valid with sw_req |
| tr_sel | output | 16 | Task register selector |
| tr_base | output | 32 | Task register hidden base |
| tr_limit | output | 32 | Task register hidden limit |

## Verification
The lookup selector is combinational, so it is due in the same cycle the request is driven. The pulses, nt_new and the task register contents are due one clock edge after the request is sampled. The bench drives each request on a falling edge and holds it through one rising edge. It reads every registered result on the following falling edge, then reads again one cycle later to confirm that the pulses have ended and the task register has held.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [1:0] {XF_JMP = 2'd0, XF_CALL = 2'd1, XF_INT = 2'd2, XF_IRET = 2'd3} xfer_e;
  typedef enum logic [1:0] {DK_OTHER = 2'd0, DK_TSS = 2'd1, DK_GATE = 2'd2, DK_RSVD = 2'd3} desc_e;

  // strictly-greater minimum compare, minimum picked by segment flavour
  function automatic logic limit_ok(input logic [31:0] lim, input logic is32,
                                    input logic [31:0] min32, input logic [31:0] min16);
    return is32 ? (lim > min32) : (lim > min16);
  endfunction
endpackage

// File: rtl/tsw_decide.sv
module tsw_decide
  import tsw_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic [1:0]       xfer_kind,
  input  logic [1:0]       desc_kind,
  input  logic             eflags_nt,
  input  logic [SEL_W-1:0] ref_sel,
  input  logic [SEL_W-1:0] gate_sel,
  input  logic [SEL_W-1:0] link_sel,
  output logic             want_switch,
  output logic             want_ret,
  output logic             nt_for_new,
  output logic [SEL_W-1:0] target_sel
);
  xfer_e kind;
  desc_e dk;
  assign kind = xfer_e'(xfer_kind);
  assign dk   = desc_e'(desc_kind);

  always_comb begin
    want_switch = 1'b0;
    want_ret    = 1'b0;
    nt_for_new  = 1'b0;
    target_sel  = ref_sel;
    unique case (kind)
      XF_JMP, XF_CALL: begin
        want_switch = (dk == DK_TSS) || (dk == DK_GATE);
        target_sel  = (dk == DK_GATE) ? gate_sel : ref_sel;
        nt_for_new  = (kind == XF_CALL);
      end
      XF_INT: begin
        want_switch = (dk == DK_GATE);
        target_sel  = gate_sel;
        nt_for_new  = 1'b1;
      end
      XF_IRET: begin
        want_switch = eflags_nt;
        want_ret    = !eflags_nt;
        target_sel  = link_sel;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tsw_task_reg.sv
module tsw_task_reg #(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEL_W-1:0]  new_sel,
  input  logic [ADDR_W-1:0] new_base,
  input  logic [ADDR_W-1:0] new_limit,
  output logic [SEL_W-1:0]  tr_sel,
  output logic [ADDR_W-1:0] tr_base,
  output logic [ADDR_W-1:0] tr_limit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tr_sel   <= '0;
      tr_base  <= '0;
      tr_limit <= '0;
    end else if (load) begin
      tr_sel   <= new_sel;
      tr_base  <= new_base;
      tr_limit <= new_limit;
    end
  end

  // R11
  tr_whole_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) && $past(rst_n) |-> (tr_sel == $past(new_sel)) && (tr_base == $past(new_base))
                                    && (tr_limit == $past(new_limit)));
endmodule

// File: rtl/task_switch_ctl.sv
module task_switch_ctl
  import tsw_pkg::*;
#(
  parameter int          SEL_W     = 16,
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] MIN_LIM32 = 32'h0000_0064,
  parameter logic [31:0] MIN_LIM16 = 32'h0000_002B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        xfer_kind,
  input  logic [1:0]        desc_kind,
  input  logic              eflags_nt,
  input  logic [SEL_W-1:0]  ref_sel,
  input  logic [SEL_W-1:0]  gate_sel,
  input  logic [SEL_W-1:0]  link_sel,
  output logic [SEL_W-1:0]  lkp_sel,
  input  logic              lkp_is32,
  input  logic [ADDR_W-1:0] lkp_base,
  input  logic [ADDR_W-1:0] lkp_limit,
  output logic              sw_req,
  output logic              plain_ret,
  output logic              tss_fault,
  output logic              nt_new,
  output logic [SEL_W-1:0]  tr_sel,
  output logic [ADDR_W-1:0] tr_base,
  output logic [ADDR_W-1:0] tr_limit
);
  logic want_switch, want_ret, nt_for_new, lim_good;
  logic do_load, do_fault, do_ret;

  tsw_decide #(.SEL_W(SEL_W)) u_decide (
    .xfer_kind(xfer_kind), .desc_kind(desc_kind), .eflags_nt(eflags_nt),
    .ref_sel(ref_sel), .gate_sel(gate_sel), .link_sel(link_sel),
    .want_switch(want_switch), .want_ret(want_ret), .nt_for_new(nt_for_new),
    .target_sel(lkp_sel));

  assign lim_good = limit_ok(32'(lkp_limit), lkp_is32, MIN_LIM32, MIN_LIM16);
  assign do_load  = req_valid && want_switch && lim_good;
  assign do_fault = req_valid && want_switch && !lim_good;
  assign do_ret   = req_valid && want_ret;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_req    <= 1'b0;
      plain_ret <= 1'b0;
      tss_fault <= 1'b0;
      nt_new    <= 1'b0;
    end else begin
      sw_req    <= do_load;
      plain_ret <= do_ret;
      tss_fault <= do_fault;
      nt_new    <= do_load && nt_for_new;
    end
  end

  tsw_task_reg #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_tr (
    .clk(clk), .rst_n(rst_n), .load(do_load),
    .new_sel(lkp_sel), .new_base(lkp_base), .new_limit(lkp_limit),
    .tr_sel(tr_sel), .tr_base(tr_base), .tr_limit(tr_limit));

  // R13
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_req, plain_ret, tss_fault}));

  // R13
  pulse_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req || plain_ret || tss_fault) |-> $past(req_valid));

  // R10
  fault_keeps_tr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tss_fault |-> $stable(tr_sel) && $stable(tr_base) && $stable(tr_limit));

  // R5
  plain_ret_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plain_ret |-> ($past(xfer_kind) == XF_IRET) && !$past(eflags_nt) && $stable(tr_sel));

  // R9
  switch_min_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> (32'(tr_limit) > MIN_LIM16));

  // R12
  nt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nt_new |-> sw_req && ($past(xfer_kind) != XF_JMP) && ($past(xfer_kind) != XF_IRET));
endmodule

// File: tb/test_task_switch_ctl.sv
`timescale 1ns/1ps
module test_task_switch_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] xfer_kind = '0, desc_kind = '0;
  logic eflags_nt = 1'b0;
  logic [15:0] ref_sel = '0, gate_sel = '0, link_sel = '0, lkp_sel;
  logic lkp_is32;
  logic [31:0] lkp_base, lkp_limit;
  logic sw_req, plain_ret, tss_fault, nt_new;
  logic [15:0] tr_sel;
  logic [31:0] tr_base, tr_limit;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  task_switch_ctl i_task_switch_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .xfer_kind(xfer_kind),
    .desc_kind(desc_kind), .eflags_nt(eflags_nt), .ref_sel(ref_sel),
    .gate_sel(gate_sel), .link_sel(link_sel), .lkp_sel(lkp_sel),
    .lkp_is32(lkp_is32), .lkp_base(lkp_base), .lkp_limit(lkp_limit),
    .sw_req(sw_req), .plain_ret(plain_ret), .tss_fault(tss_fault), .nt_new(nt_new),
    .tr_sel(tr_sel), .tr_base(tr_base), .tr_limit(tr_limit));

  // descriptor table model: bit 15 marks a legacy 16-bit segment
  function automatic logic [31:0] lim_of(input logic [15:0] s);
    case (s)
      16'h0010: return 32'h67;
      16'h0018: return 32'h64;
      16'h0020: return 32'h65;
      16'h8028: return 32'h2B;
      16'h8030: return 32'h2C;
      default:  return 32'hFFFF_FFFF;
    endcase
  endfunction
  always_comb begin
    lkp_is32  = !lkp_sel[15];
    lkp_base  = {lkp_sel, 16'h1000};
    lkp_limit = lim_of(lkp_sel);
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {kind, dk, nt, ref, gate, link, exp_sw, exp_ret, exp_flt, exp_nt}
  localparam int NV = 12;
  localparam logic [56:0] VEC [NV] = '{
    {2'd0, 2'd1, 1'b0, 16'h0010, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 jmp tss
    {2'd1, 2'd2, 1'b0, 16'h00F0, 16'h0020, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 call gate
    {2'd1, 2'd0, 1'b0, 16'h0010, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    {2'd0, 2'd1, 1'b0, 16'h0018, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 0x64
    {2'd2, 2'd2, 1'b0, 16'h0000, 16'h8030, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 R9 0x2C
    {2'd2, 2'd1, 1'b0, 16'h0010, 16'h0038, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 tss slot
    {2'd2, 2'd0, 1'b0, 16'h0010, 16'h0038, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 other
    {2'd1, 2'd1, 1'b0, 16'h8028, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R9 0x2B
    {2'd3, 2'd0, 1'b0, 16'h0010, 16'h0000, 16'h0010, 1'b0, 1'b1, 1'b0, 1'b0}, // R5
    {2'd3, 2'd0, 1'b1, 16'h0000, 16'h0000, 16'h0038, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 R8 4G
    {2'd0, 2'd2, 1'b0, 16'h0010, 16'h0018, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R10 gate
    {2'd0, 2'd1, 1'b1, 16'h0020, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0}  // R8 0x65 R12
  };

  logic [15:0] exp_sel;
  logic [31:0] exp_base, exp_lim;

  initial begin
    #40000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pulses", {sw_req, plain_ret, tss_fault, nt_new}, 4'b0);
    check("R1 tr_sel", tr_sel, 16'h0);
    check("R1 tr_base", tr_base, 32'h0);
    check("R1 tr_limit", tr_limit, 32'h0);
    exp_sel = '0; exp_base = '0; exp_lim = '0;

    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      logic [15:0] tgt;
      v = VEC[i];
      xfer_kind = v[56:55]; desc_kind = v[54:53]; eflags_nt = v[52];
      ref_sel = v[51:36]; gate_sel = v[35:20]; link_sel = v[19:4];
      req_valid = 1'b1;
      tgt = (v[56:55] == 2'd3) ? v[19:4] : (v[54:53] == 2'd2) ? v[35:20] : v[51:36];
      #1;
      if (v[3] || v[1]) check("R7 lkp_sel", lkp_sel, tgt);
      @(negedge clk);
      req_valid = 1'b0;
      if (v[3]) begin
        exp_sel = tgt; exp_base = {tgt, 16'h1000}; exp_lim = lim_of(tgt);
      end
      check($sformatf("R2 R4 R6 sw_req vec%0d", i), sw_req, v[3]);
      check($sformatf("R5 plain_ret vec%0d", i), plain_ret, v[2]);
      check($sformatf("R8 R9 R10 tss_fault vec%0d", i), tss_fault, v[1]);
      check($sformatf("R12 nt_new vec%0d", i), nt_new, v[0]);
      check($sformatf("R11 R3 tr vec%0d", i), {tr_sel, tr_base, tr_limit}, {exp_sel, exp_base, exp_lim});
      @(negedge clk);
      check($sformatf("R13 pulse ended vec%0d", i), {sw_req, plain_ret, tss_fault, nt_new}, 4'b0);
      check($sformatf("R11 tr held vec%0d", i), tr_sel, exp_sel);
    end

    // R13 no request: valid inputs that would switch, req_valid low
    xfer_kind = 2'd0; desc_kind = 2'd1; ref_sel = 16'h0038;
    @(negedge clk);
    @(negedge clk);
    check("R13 idle no pulse", {sw_req, plain_ret, tss_fault}, 3'b0);
    check("R13 idle tr kept", tr_sel, exp_sel);

    // R1 reset again clears the task register
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset clears tr", {tr_sel, tr_base, tr_limit}, 80'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule